// File: doc/BRIEF.md
# UART Modem Control and Loopback Logic

This block keeps the line-control bits that force a transmit break and select the divisor latches, together with the modem control register of a 16550-style UART. From these bits it drives the outgoing modem handshake pins, the buffered reset pin and the enable of the three-state interrupt driver. It also gates the serial transmit line. Software writes and reads the two registers through a one-bit-address register port. The `soft_rst_en` input carries a bit of the interrupt-enable register, which is kept elsewhere.

In internal loopback mode, the block sends the control bits and the serial transmit stream back to the internal modem-status and receive inputs. The external modem inputs and receive pin are then ignored. The external transmit pin is parked at mark and the external handshake outputs are parked inactive. Outside loopback, the internal status inputs are taken straight from the pins.

Top module: `uart_modem_ctl`

## Requirements
- R1: While `rst_hw` is high, and after it falls, all register bits read 0. `dtr_n` and `rts_n` are 1 and `int_oe` is 0.
- R2: Address 0 is the line-control register and reads back bits 7 and 6 as written, with bits 5..0 read as 0. Address 1 is the modem-control register and reads back bits 4..0 as written, with bits 7..5 read as 0. A write takes effect at the next rising clock edge.
- R3: Outside loopback, `tx_pin` is 0 while line-control bit 6 (break) is 1, and equals `tx_raw` otherwise.
- R4: `div_sel` equals line-control bit 7 (1 = divisor latches, 0 = data registers).
- R5: Outside loopback, `dtr_n` is the inverse of modem-control bit 0 and `rts_n` is the inverse of bit 1.
- R6: Outside loopback, `rst_out` = `rst_hw` OR (`soft_rst_en` AND modem-control bit 2). Setting bit 2 never clears any register of the block.
- R7: Outside loopback, `int_oe` equals modem-control bit 3 (0 = interrupt line three-state, 1 = driven active high).
- R8: Modem-control bit 4 = 1 selects loopback. In loopback, the internal status inputs take these values: `ri_n_int` = NOT bit 2, `cd_n_int` = NOT bit 3, `dsr_n_int` = NOT bit 0, `cts_n_int` = NOT bit 1. `rx_int` equals `tx_raw` with break applied. The external modem pins and `rx_pin` have no effect.
- R9: In loopback, `tx_pin`, `dtr_n` and `rts_n` are 1, `int_oe` is 0, and `rst_out` equals `rst_hw`.
- R10: Outside loopback, `rx_int`, `cts_n_int`, `dsr_n_int`, `ri_n_int` and `cd_n_int` equal `rx_pin`, `cts_n_pin`, `dsr_n_pin`, `ri_n_pin` and `cd_n_pin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_hw | input | 1 | Hardware reset, active high, asynchronous |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select: 0 line control, 1 modem control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| soft_rst_en | input | 1 | Interrupt-enable bit that allows the soft reset onto `rst_out` |
| tx_raw | input | 1 | Serial data from the serializer |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rx_int | output | 1 | Serial data to the deserializer |
| cts_n_pin | input | 1 | External clear-to-send, active low |
| dsr_n_pin | input | 1 | External data-set-ready, active low |
| ri_n_pin | input | 1 | External ring indicator, active low |
| cd_n_pin | input | 1 | External carrier detect, active low |
| cts_n_int | output | 1 | Internal clear-to-send to the status logic |
| dsr_n_int | output | 1 | Internal data-set-ready |
| ri_n_int | output | 1 | Internal ring indicator |
| cd_n_int | output | 1 | Internal carrier detect |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| rts_n | output | 1 | Request-to-send pin, active low |
| rst_out | output | 1 | Buffered reset pin |
| int_oe | output | 1 | Output enable of the interrupt driver |
| div_sel | output | 1 | Divisor latch select for the shared addresses |

## Verification
The hardest case to reach is a soft reset bit set while loopback is on. Its effect on `rst_out` must vanish there, and it must still appear on the ring-indicator input. The bench sets bit 2 with `soft_rst_en` high, turns loopback on and off around it, and checks `rst_out` and `ri_n_int` in each state. It holds the external pins at values opposite to the expected internal ones, so that a leak through the loopback multiplexer shows up.

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl (
  input  logic       clk,
  input  logic       rst_hw,
  input  logic       wr_en,
  input  logic       addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       soft_rst_en,
  input  logic       tx_raw,
  output logic       tx_pin,
  input  logic       rx_pin,
  output logic       rx_int,
  input  logic       cts_n_pin,
  input  logic       dsr_n_pin,
  input  logic       ri_n_pin,
  input  logic       cd_n_pin,
  output logic       cts_n_int,
  output logic       dsr_n_int,
  output logic       ri_n_int,
  output logic       cd_n_int,
  output logic       dtr_n,
  output logic       rts_n,
  output logic       rst_out,
  output logic       int_oe,
  output logic       div_sel
);
  logic       brk, dsel;
  logic [4:0] mcr;
  logic       loop, tx_g;

  always_ff @(posedge clk or posedge rst_hw) begin
    if (rst_hw) begin
      brk  <= 1'b0;
      dsel <= 1'b0;
      mcr  <= '0;
    end else if (wr_en) begin
      if (addr) mcr <= wr_data[4:0];
      else begin
        brk  <= wr_data[6];
        dsel <= wr_data[7];
      end
    end
  end

  assign loop    = mcr[4];
  assign tx_g    = tx_raw & ~brk;
  assign rd_data = addr ? {3'b000, mcr} : {dsel, brk, 6'b0};
  assign div_sel = dsel;

  assign tx_pin  = loop | tx_g;
  assign dtr_n   = loop | ~mcr[0];
  assign rts_n   = loop | ~mcr[1];
  assign int_oe  = ~loop & mcr[3];
  assign rst_out = rst_hw | (~loop & soft_rst_en & mcr[2]);

  assign rx_int    = loop ? tx_g    : rx_pin;
  assign dsr_n_int = loop ? ~mcr[0] : dsr_n_pin;
  assign cts_n_int = loop ? ~mcr[1] : cts_n_pin;
  assign ri_n_int  = loop ? ~mcr[2] : ri_n_pin;
  assign cd_n_int  = loop ? ~mcr[3] : cd_n_pin;
endmodule

module uart_modem_ctl_chk (
  input logic       clk,
  input logic       rst_hw,
  input logic       wr_en,
  input logic       addr,
  input logic [7:0] wr_data,
  input logic [7:0] rd_data,
  input logic       soft_rst_en,
  input logic       tx_pin,
  input logic       dtr_n,
  input logic       rts_n,
  input logic       rst_out,
  input logic       int_oe,
  input logic       ri_n_int,
  input logic [4:0] mcr,
  input logic       brk
);
  // R1
  rst_clear_chk: assert property (@(posedge clk) rst_hw |-> (dtr_n && rts_n && !int_oe));
  // R2
  mcr_hold_chk: assert property (@(posedge clk) disable iff (rst_hw)
    !wr_en |=> $stable(mcr));
  // R3
  brk_tx_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (brk && !mcr[4]) |-> !tx_pin);
  // R5
  dtr_wr_chk: assert property (@(posedge clk) disable iff (rst_hw)
    (wr_en && addr && !wr_data[4]) |=> (dtr_n == !$past(wr_data[0])));
  // R6
  rst_follow_chk: assert property (@(posedge clk) rst_hw |-> rst_out);
  // R8
  loop_ri_chk: assert property (@(posedge clk) disable iff (rst_hw)
    mcr[4] |-> (ri_n_int == !rd_data[2] || !addr));
  // R9
  loop_park_chk: assert property (@(posedge clk) disable iff (rst_hw)
    mcr[4] |-> (tx_pin && dtr_n && rts_n && !int_oe && !rst_out));
endmodule

bind uart_modem_ctl uart_modem_ctl_chk u_chk (
  .clk(clk), .rst_hw(rst_hw), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .rd_data(rd_data), .soft_rst_en(soft_rst_en), .tx_pin(tx_pin), .dtr_n(dtr_n),
  .rts_n(rts_n), .rst_out(rst_out), .int_oe(int_oe), .ri_n_int(ri_n_int),
  .mcr(mcr), .brk(brk)
);

// File: tb/tb_uart_modem_ctl.sv
module tb_uart_modem_ctl;
  logic clk = 0, rst_hw = 1, wr_en = 0, addr = 0, soft_rst_en = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic tx_raw = 1, rx_pin = 1, cts_n_pin = 1, dsr_n_pin = 1, ri_n_pin = 1, cd_n_pin = 1;
  logic tx_pin, rx_int, cts_n_int, dsr_n_int, ri_n_int, cd_n_int;
  logic dtr_n, rts_n, rst_out, int_oe, div_sel;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  uart_modem_ctl dut (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    @(negedge clk);
    chk("R1 dtr/rts/int_oe in reset", {dtr_n, rts_n, int_oe}, 3'b110);
    chk("R6 rst_out follows rst_hw", rst_out, 1);
    rst_hw = 0;
    rd(0, v); chk("R1 lcr after reset", v, 0);
    rd(1, v); chk("R1 mcr after reset", v, 0);
    chk("R4 div_sel after reset", div_sel, 0);
    chk("R6 rst_out low", rst_out, 0);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    wr(0, 8'hFF); rd(0, v); chk("R2 lcr readback", v, 8'hC0);
    chk("R4 div_sel set", div_sel, 1);
    wr(0, 8'h3F); rd(0, v); chk("R2 lcr low bits", v, 8'h00);
    chk("R4 div_sel clear", div_sel, 0);
    wr(1, 8'hEB); rd(1, v); chk("R2 mcr readback", v, 8'h0B);
    wr(1, 8'h00);
  endtask

  task automatic t_break;
    tx_raw = 1; @(negedge clk); chk("R3 tx idle", tx_pin, 1);
    tx_raw = 0; #1 chk("R3 tx follows raw", tx_pin, 0);
    tx_raw = 1; wr(0, 8'h40); chk("R3 break forces 0", tx_pin, 0);
    wr(0, 8'h00); chk("R3 break released", tx_pin, 1);
  endtask

  task automatic t_modem_out;
    wr(1, 8'h01); chk("R5 dtr only", {dtr_n, rts_n}, 2'b01);
    wr(1, 8'h02); chk("R5 rts only", {dtr_n, rts_n}, 2'b10);
    wr(1, 8'h08); chk("R7 int_oe on", int_oe, 1);
    wr(1, 8'h00); chk("R7 int_oe off", int_oe, 0);
  endtask

  task automatic t_rst_or;
    logic [7:0] v;
    soft_rst_en = 0; wr(1, 8'h04); chk("R6 soft reset gated off", rst_out, 0);
    soft_rst_en = 1; #1 chk("R6 soft reset ORed", rst_out, 1);
    wr(0, 8'h80);
    rd(1, v); chk("R6 soft reset keeps mcr", v, 8'h04);
    rd(0, v); chk("R6 soft reset keeps lcr", v, 8'h80);
    wr(1, 8'h14); chk("R9 loop hides soft reset", rst_out, 0);
    chk("R8 ri from bit2", ri_n_int, 0);
    wr(1, 8'h04); chk("R6 soft reset back", rst_out, 1);
    chk("R10 ri from pin", ri_n_int, 1);
    wr(1, 8'h00); soft_rst_en = 0; wr(0, 8'h00);
  endtask

  task automatic t_loopback;
    rx_pin = 0; cts_n_pin = 0; dsr_n_pin = 0; ri_n_pin = 0; cd_n_pin = 0;
    wr(1, 8'h1B);
    chk("R9 park pins", {tx_pin, dtr_n, rts_n, int_oe}, 4'b1110);
    chk("R8 internal status", {dsr_n_int, cts_n_int, ri_n_int, cd_n_int}, 4'b0010);
    tx_raw = 1; #1 chk("R8 rx from tx", rx_int, 1);
    tx_raw = 0; #1 chk("R8 rx follows tx low", rx_int, 0);
    tx_raw = 1; wr(0, 8'h40); chk("R8 break loops", rx_int, 0);
    chk("R9 tx parked under break", tx_pin, 1);
    wr(0, 8'h00);
    rx_pin = 1; cts_n_pin = 1; dsr_n_pin = 1; ri_n_pin = 1; cd_n_pin = 1;
    wr(1, 8'h10);
    chk("R8 pins ignored", {rx_int, dsr_n_int, cts_n_int, ri_n_int, cd_n_int}, 5'b11111);
    rx_pin = 0; cts_n_pin = 0; #1
    chk("R8 pins ignored 2", {rx_int, cts_n_int}, 2'b11);
    wr(1, 8'h00);
    chk("R10 pins pass", {rx_int, cts_n_int, dsr_n_int}, 3'b001);
    rx_pin = 1; cts_n_pin = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset; t_readback; t_break; t_modem_out; t_rst_or; t_loopback;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule